// File: doc/BRIEF.md
# Bus-Snooping Signature Compressor Channel

This block is a single signature-compression channel on a register slave port. It keeps a 64-bit signature that either software or a snooped CPU read bus folds data into. In data capture mode, a software write to the signature plants a seed. With tracing switched on, every completed read seen on the snooped bus is compressed into the signature. In a nonzero compress mode, each software write to the signature is compressed into it. Compression processes each 64-bit word MSB first against the polynomial x^64+x^4+x^3+x+1. The result is new = step(old) XOR data, where step(old) shifts the old value through 64 zero-input CRC steps.

The channel also has the following:
- a word counter that raises a completion flag;
- an overrun flag;
- a reloadable timeout counter;
- an interrupt offset register that names the highest-priority pending flag and clears it when read.

A debug suspend input freezes compression and the timeout counter. Under suspend, reads of the offset register have no side effect and reads of unused locations do not fault. A power-down bit stops tracing, except for reads that target this channel's own register window.

The register port answers in the same cycle it is selected. Register side effects take place on the clock edge that ends the access.

Top module: `sig_snoop_chan`

## Requirements
- R1: In data capture mode (control bits [1:0] = 0), a write to the signature register (index 1) loads the written value unchanged as the seed.
- R2: With trace enabled (control bit 4), a snoop read strobe replaces the signature with step(sig) XOR snp_data. Here step is 64 MSB-first zero-input CRC shifts with feedback constant 0x1B.
- R3: A control write (index 0) that sets the trace bit forces the mode field to 0 in that same write, whatever mode value the write carries.
- R4: The mode field changes only while the software reset bit (control bit 5) was already set before the write, and only to or from 0. Any other mode change is ignored. While software reset is set, the signature reads 0 and writes to it are ignored.
- R5: In a nonzero mode, a write to the signature register replaces it with step(sig) XOR written data.
- R6: While the power-down bit (control bit 6) is set, a snooped read is compressed only if its byte address lies in the channel's own window (bits [31:7] equal to those of BASE_ADDR). Clearing the bit resumes compression of all snooped reads.
- R7: The offset register (index 4) reads 1 for a pending timeout, else 2 for an overrun, else 3 for a completion, else 0. Outside suspend, that read clears the reported flag. The status register (index 3) holds timeout in bit 0, overrun in bit 1 and completion in bit 2, and output irq is the OR of these bits.
- R8: While dbg_suspend is high, an offset register read returns its code and leaves every status flag set.
- R9: While dbg_suspend is high, snooped reads do not change the signature.
- R10: A write to the preload register (index 2), or any compression, reloads the timeout counter from the preload value. With a nonzero preload and no further compression, the timeout flag sets on the preload-th clock edge that follows, counting only edges where dbg_suspend is low.
- R11: With a nonzero word target (index 5), the completion flag sets when the target count of words has been compressed. A compression made while the completion flag is still pending sets the overrun flag.
- R12: An access to an index above 5 raises bus_err in the same cycle. The one exception is a read while dbg_suspend is high, which returns 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, same cycle |
| bus_err | output | 1 | Abort response, same cycle |
| snp_rd | input | 1 | Completed read on the snooped bus |
| snp_addr | input | 32 | Byte address of the snooped read |
| snp_data | input | 64 | Data of the snooped read |
| dbg_suspend | input | 1 | Debug suspend |
| irq | output | 1 | Any status flag pending |

## Verification
The hardest state to reach is one where several flags are pending at once and their order of clearing shows the priority. To get there, the bench sets a word target of two and sends three snoops, which leaves overrun and completion pending together. It then reads the offset register under suspend and outside it. The timeout freeze is also hard to show, because it is visible only through irq timing. The bench holds suspend across more edges than the preload count, then counts edges after release to the exact firing edge.

// File: rtl/sig_snoop_chan.sv
module sig_snoop_chan #(
  parameter int          AW        = 4,
  parameter int          TW        = 16,
  parameter int          CW        = 16,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_F000,
  parameter logic [63:0] POLY      = 64'h1B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [63:0]   bus_wdata,
  output logic [63:0]   bus_rdata,
  output logic          bus_err,
  input  logic          snp_rd,
  input  logic [31:0]   snp_addr,
  input  logic [63:0]   snp_data,
  input  logic          dbg_suspend,
  output logic          irq
);
  localparam int OWN_LSB = AW + 3;
  localparam logic [AW-1:0] IX_CTRL = AW'(0), IX_SIG = AW'(1), IX_PRE = AW'(2),
                            IX_STAT = AW'(3), IX_OFF = AW'(4), IX_TGT = AW'(5);

  function automatic logic [63:0] crc_step(input logic [63:0] c);
    logic [63:0] r;
    r = c;
    for (int i = 0; i < 64; i++) r = {r[62:0], 1'b0} ^ (r[63] ? POLY : 64'd0);
    return r;
  endfunction

  logic [1:0]    mode_q;
  logic          trace_q, swr_q, pwdn_q, armed_q;
  logic [63:0]   sig_q;
  logic [TW-1:0] pre_q, tcnt_q;
  logic [CW-1:0] tgt_q, wcnt_q;
  logic [2:0]    st_q, st_set, st_clr;
  logic [1:0]    code;

  wire wr    = bus_sel & bus_wr;
  wire rd    = bus_sel & ~bus_wr;
  wire legal = bus_addr <= IX_TGT;
  assign bus_err = bus_sel & ~legal & ~(dbg_suspend & ~bus_wr);

  wire snp_own  = snp_addr[31:OWN_LSB] == BASE_ADDR[31:OWN_LSB];
  wire snp_fire = trace_q & snp_rd & ~dbg_suspend & ~swr_q & (~pwdn_q | snp_own);
  wire sig_wr   = wr & (bus_addr == IX_SIG) & ~swr_q;
  wire seed_wr  = sig_wr & (mode_q == 2'd0);
  wire sw_fire  = sig_wr & (mode_q != 2'd0);
  wire cmp_fire = snp_fire | sw_fire;
  wire [63:0] cmp_data = sw_fire ? bus_wdata : snp_data;
  wire pre_wr   = wr & (bus_addr == IX_PRE);
  wire off_rd   = rd & (bus_addr == IX_OFF);
  wire done_hit = cmp_fire & (tgt_q != '0) & (wcnt_q == tgt_q - 1'b1);
  wire tmo_hit  = armed_q & ~dbg_suspend & ~swr_q & (tcnt_q == TW'(1)) & ~pre_wr & ~cmp_fire;

  assign code = st_q[0] ? 2'd1 : st_q[1] ? 2'd2 : st_q[2] ? 2'd3 : 2'd0;
  assign irq  = |st_q;
  assign st_set = {done_hit, cmp_fire & st_q[2], tmo_hit};
  assign st_clr = ((wr && bus_addr == IX_STAT) ? bus_wdata[2:0] : 3'b0)
                | ((off_rd && !dbg_suspend && code != 2'd0) ? 3'(1 << (code - 2'd1)) : 3'b0);

  always_comb begin
    bus_rdata = 64'd0;
    if (rd) begin
      case (bus_addr)
        IX_CTRL: bus_rdata = {57'd0, pwdn_q, swr_q, trace_q, 2'b00, mode_q};
        IX_SIG:  bus_rdata = sig_q;
        IX_PRE:  bus_rdata = 64'(pre_q);
        IX_STAT: bus_rdata = {61'd0, st_q};
        IX_OFF:  bus_rdata = {62'd0, code};
        IX_TGT:  bus_rdata = 64'(tgt_q);
        default: bus_rdata = 64'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'd0; trace_q <= 1'b0; swr_q <= 1'b0; pwdn_q <= 1'b0;
    end else if (wr && bus_addr == IX_CTRL) begin
      trace_q <= bus_wdata[4];
      swr_q   <= bus_wdata[5];
      pwdn_q  <= bus_wdata[6];
      if (bus_wdata[4]) mode_q <= 2'd0;
      else if (swr_q && (mode_q == 2'd0 || bus_wdata[1:0] == 2'd0)) mode_q <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sig_q <= 64'd0;
    else if (swr_q)    sig_q <= 64'd0;
    else if (seed_wr)  sig_q <= bus_wdata;
    else if (cmp_fire) sig_q <= crc_step(sig_q) ^ cmp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0; tcnt_q <= '0; armed_q <= 1'b0; tgt_q <= '0; wcnt_q <= '0; st_q <= 3'b0;
    end else begin
      st_q <= (st_q & ~st_clr) | st_set;
      if (wr && bus_addr == IX_TGT) tgt_q <= bus_wdata[CW-1:0];
      if (swr_q) wcnt_q <= '0;
      else if (cmp_fire && tgt_q != '0) wcnt_q <= done_hit ? '0 : wcnt_q + 1'b1;
      if (pre_wr) begin
        pre_q   <= bus_wdata[TW-1:0];
        tcnt_q  <= bus_wdata[TW-1:0];
        armed_q <= bus_wdata[TW-1:0] != '0;
      end else if (cmp_fire) begin
        tcnt_q  <= pre_q;
        armed_q <= pre_q != '0;
      end else if (armed_q && !dbg_suspend && !swr_q) begin
        tcnt_q <= tcnt_q - 1'b1;
        if (tcnt_q == TW'(1)) armed_q <= 1'b0;
      end
    end
  end

  p_sig_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swr_q |=> sig_q == 64'd0);
  p_trace_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_q) |-> mode_q == 2'd0);
  p_susp_sig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_suspend && !wr && !swr_q) |=> $stable(sig_q));
  p_susp_tmo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_suspend && !wr) |=> $stable(tcnt_q));
  p_susp_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (off_rd && dbg_suspend) |=> (($past(st_q) & ~st_q) == 3'b0));
  p_susp_noerr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_suspend && bus_sel && !bus_wr) |-> !bus_err);
endmodule

// File: tb/sig_snoop_chan_tb.sv
module sig_snoop_chan_tb;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, snp_rd = 0, dbg_suspend = 0;
  logic [3:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0, snp_data = '0, bus_rdata;
  logic [31:0] snp_addr = '0;
  logic bus_err, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] OWN = 32'hFFFF_F010, FAR = 32'h0000_1000;
  localparam logic [127:0] VEC [4] = '{
    {64'h0, 64'h0123_4567_89AB_CDEF},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {64'h8000_0000_0000_0000, 64'h1},
    {64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_3333_CCCC}};

  sig_snoop_chan u_dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .bus_err, .snp_rd, .snp_addr, .snp_data, .dbg_suspend, .irq);

  always #2.5 clk = ~clk;

  function automatic logic [63:0] ref_step(input logic [63:0] c);
    logic [63:0] r = c;
    for (int i = 0; i < 64; i++) begin
      logic fb = r[63];
      r = r << 1;
      if (fb) r = r ^ 64'h1B;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [3:0] a, input logic [63:0] d,
                     output logic [63:0] rdat, output logic err);
    @(negedge clk);
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1 rdat = bus_rdata; err = bus_err;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    logic [63:0] r; logic e;
    acc(1, a, d, r, e);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [63:0] exp);
    logic [63:0] r; logic e;
    acc(0, a, 0, r, e);
    check(req, r, exp);
  endtask

  task automatic snoop(input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    snp_rd = 1; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] s, r;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd_chk("R4 reset ctrl", 0, 0);
    rd_chk("R1 reset sig", 1, 0);
    rd_chk("R7 reset offset", 4, 0);
    check("R7 reset irq", irq, 0);

    // vector table: seed then snooped word
    wr(0, 64'h10);
    for (int i = 0; i < 4; i++) begin
      wr(1, VEC[i][127:64]);
      rd_chk("R1 seed", 1, VEC[i][127:64]);
      snoop(FAR, VEC[i][63:0]);
      rd_chk("R2 snoop compress", 1, ref_step(VEC[i][127:64]) ^ VEC[i][63:0]);
    end

    // enter mode 1 by the legal order
    wr(0, 0); wr(0, 32); wr(0, 33); wr(0, 1);
    rd_chk("R4 legal change to 1", 0, 1);
    wr(1, 64'hA5);
    rd_chk("R5 sw compress first", 1, 64'hA5);
    wr(1, 64'h1234);
    rd_chk("R5 sw compress second", 1, ref_step(64'hA5) ^ 64'h1234);
    wr(0, 2);
    rd_chk("R4 change without reset ignored", 0, 1);
    wr(0, 32); wr(0, 34);
    rd_chk("R4 nonzero to nonzero ignored", 0, 33);
    rd_chk("R4 sig held under reset", 1, 0);
    wr(1, 64'h77);
    rd_chk("R4 sig write ignored under reset", 1, 0);
    wr(0, 32); wr(0, 34); wr(0, 2);
    rd_chk("R4 legal change to 2", 0, 2);
    wr(0, 16 | 2);
    rd_chk("R3 trace forces mode 0", 0, 16);

    // power down
    s = 64'h0F0F_0000_1111_2222;
    wr(1, s);
    wr(0, 16 | 64);
    snoop(FAR, 64'h99);
    rd_chk("R6 far read not traced in power-down", 1, s);
    snoop(OWN, 64'h99);
    s = ref_step(s) ^ 64'h99;
    rd_chk("R6 own read traced in power-down", 1, s);
    wr(0, 16);
    snoop(FAR, 64'h42);
    s = ref_step(s) ^ 64'h42;
    rd_chk("R6 resumes after power-down", 1, s);

    // suspend freezes compression
    @(negedge clk); dbg_suspend = 1;
    snoop(FAR, 64'h3);
    rd_chk("R9 no compress in suspend", 1, s);
    @(negedge clk); dbg_suspend = 0;

    // completion, overrun, offset priority
    wr(5, 2);
    snoop(FAR, 1); snoop(FAR, 2);
    rd_chk("R11 completion flag", 3, 4);
    snoop(FAR, 3);
    rd_chk("R11 overrun flag", 3, 6);
    @(negedge clk); dbg_suspend = 1;
    rd_chk("R8 offset in suspend", 4, 2);
    rd_chk("R8 flags kept", 3, 6);
    @(negedge clk); dbg_suspend = 0;
    rd_chk("R7 offset overrun", 4, 2);
    rd_chk("R7 overrun cleared", 3, 4);
    rd_chk("R7 offset completion", 4, 3);
    rd_chk("R7 offset none", 4, 0);
    check("R7 irq low", irq, 0);
    wr(5, 0);

    // timeout
    wr(2, 5);
    repeat (4) @(negedge clk);
    check("R10 no timeout before count", irq, 0);
    @(negedge clk);
    check("R10 timeout on count", irq, 1);
    rd_chk("R7 offset timeout", 4, 1);
    @(negedge clk); dbg_suspend = 1;
    wr(2, 5);
    repeat (10) @(negedge clk);
    check("R10 frozen in suspend", irq, 0);
    dbg_suspend = 0;
    repeat (4) @(negedge clk);
    check("R10 not yet after release", irq, 0);
    @(negedge clk);
    check("R10 fires after release", irq, 1);
    wr(2, 0);
    wr(3, 7);

    // abort
    acc(0, 9, 0, r, e);
    check("R12 illegal read aborts", e, 1);
    @(negedge clk); dbg_suspend = 1;
    acc(0, 9, 0, r, e);
    check("R12 suspend read no abort", e, 0);
    check("R12 suspend read data", r, 0);
    acc(1, 9, 1, r, e);
    check("R12 suspend write aborts", e, 1);
    @(negedge clk); dbg_suspend = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule